// File: doc/BRIEF.md
# Motor Stall Guard Timer

This block guards a motor against a stalled rotor. While the motor is commanded to run and the speed loop reports that it is not locked, an up/down accumulator fills at a slow rate. It stands in for a timing capacitor that is being charged. When the accumulated count reaches a programmable interval, a latched trip flag turns off the low-side drivers. Once set, the flag stays set until the run command drops or the block is reset.

During stop the accumulator drains much faster than it fills, by 22 counts per step against 1. A short stop therefore leaves part of the earlier count in place, and the next trip comes sooner. While running and locked, the count holds its value. Pulling the enable low grounds the model capacitor: the count is held at zero and no new trip can start. A step prescaler can slow both the fill and the drain rates. With a divide of one, every clock is a step.

Top module: `stall_guard_top`

## Requirements
- R1: With run high, enable high and lock low, the count rises by one per step. Starting from zero with interval L, trip_o is low after L steps and high after L+1 steps.
- R2: With run high and lock high, the count holds its value: it neither fills nor drains.
- R3: Once trip_o is high, it stays high while run is high, whatever lock and enable do.
- R4: Run low clears trip_o on the next clock edge.
- R5: With run low and enable high, each step lowers the count by 22. The count stops at zero and never wraps.
- R6: A count left over from an incomplete drain stays in place, so the next trip comes that many steps sooner.
- R7: While filling, the count saturates at the interval. A long unlocked run does not push it past the interval.
- R8: Enable low forces the count to zero and stops trip_o from being set. A trip that is already latched is kept.
- R9: Asynchronous reset (rst_ni low) clears trip_o and the count at once.
- R10: An interval of zero trips on the first step of unlocked running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| run_i | input | 1 | Run command: 1 run, 0 stop |
| locked_i | input | 1 | Speed lock status: 1 locked, 0 unlocked |
| guard_en_i | input | 1 | Protection enable: 0 holds the count at zero |
| interval_i | input | ACC_W (12) | Trip interval in steps |
| trip_o | output | 1 | Latched trip: 1 turns the low-side drivers off |

## Verification
The bench aims at the drain floor. A design that wraps below zero would trip almost at once after a double stop. It also aims at the fill ceiling: without saturation, a long unlocked run would leave a count that survives one stop and trips on the first cycle of the restart. Holding while locked is checked by splitting an unlocked run around a long locked stretch. A design that drains there would never reach the trip. The residual-count case and the enable-clears-residual case measure the exact trip cycle, so a drain step or clear that is off by one shows up as an early or late trip.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

   // Operation applied to the stall accumulator in one cycle
   typedef enum logic [1:0] {
      ACC_CLEAR = 2'd0,
      ACC_HOLD  = 2'd1,
      ACC_DRAIN = 2'd2,
      ACC_FILL  = 2'd3
   } acc_op_e;

endpackage

// File: rtl/stall_guard_tick.sv
module stall_guard_tick #(
   parameter int unsigned PRE_DIV = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic step_o
);
   localparam int unsigned CNT_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   generate
      if (PRE_DIV <= 1) begin : g_every_cycle
         assign step_o = 1'b1;
      end else begin : g_divided
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_DIV - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign step_o = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/stall_guard_ctrl.sv
module stall_guard_ctrl
   import stall_guard_pkg::*;
(
   input  logic    run_i,
   input  logic    locked_i,
   input  logic    guard_en_i,
   input  logic    step_i,
   output acc_op_e op_o
);

   always_comb begin
      if (!guard_en_i) begin
         op_o = ACC_CLEAR;
      end else if (!step_i) begin
         op_o = ACC_HOLD;
      end else if (!run_i) begin
         op_o = ACC_DRAIN;
      end else if (locked_i) begin
         op_o = ACC_HOLD;
      end else begin
         op_o = ACC_FILL;
      end
   end

endmodule

// File: rtl/stall_guard_acc.sv
module stall_guard_acc
   import stall_guard_pkg::*;
#(
   parameter int unsigned ACC_W     = 12,
   parameter int unsigned FILL_STEP = 1,
   parameter int unsigned DRAIN_STEP = 22
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  acc_op_e          op_i,
   input  logic [ACC_W-1:0] ceil_i,
   output logic [ACC_W-1:0] acc_o
);
   localparam logic [ACC_W-1:0] FILL_V  = ACC_W'(FILL_STEP);
   localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN_STEP);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_d;
   logic [ACC_W-1:0] headroom;

   assign headroom = ceil_i - acc_q;

   always_comb begin
      acc_d = acc_q;
      unique case (op_i)
         ACC_CLEAR: acc_d = '0;
         ACC_HOLD:  acc_d = acc_q;
         ACC_DRAIN: acc_d = (acc_q > DRAIN_V) ? (acc_q - DRAIN_V) : '0;
         ACC_FILL: begin
            if (acc_q >= ceil_i) begin
               acc_d = ceil_i;
            end else if (headroom <= FILL_V) begin
               acc_d = ceil_i;
            end else begin
               acc_d = acc_q + FILL_V;
            end
         end
         default: acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_d;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/stall_guard_top.sv
module stall_guard_top
   import stall_guard_pkg::*;
#(
   parameter int unsigned ACC_W      = 12,
   parameter int unsigned FILL_STEP  = 1,
   parameter int unsigned DRAIN_STEP = 22,
   parameter int unsigned PRE_DIV    = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             locked_i,
   input  logic             guard_en_i,
   input  logic [ACC_W-1:0] interval_i,
   output logic             trip_o
);
   localparam longint unsigned ACC_MAX = (64'd1 << ACC_W) - 1;

   generate
      if (ACC_W < 2 || ACC_W > 32) begin : g_bad_width
         $error("stall_guard_top: ACC_W out of range");
      end
      if (FILL_STEP < 1 || FILL_STEP > ACC_MAX) begin : g_bad_fill
         $error("stall_guard_top: FILL_STEP out of range");
      end
      if (DRAIN_STEP < 1 || DRAIN_STEP > ACC_MAX) begin : g_bad_drain
         $error("stall_guard_top: DRAIN_STEP out of range");
      end
      if (PRE_DIV < 1) begin : g_bad_div
         $error("stall_guard_top: PRE_DIV must be at least 1");
      end
   endgenerate

   logic             step_w;
   acc_op_e          op_w;
   logic [ACC_W-1:0] acc_w;
   logic             trip_q;

   stall_guard_tick #(
      .PRE_DIV (PRE_DIV)
   ) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_o (step_w)
   );

   stall_guard_ctrl ctrl_i (
      .run_i      (run_i),
      .locked_i   (locked_i),
      .guard_en_i (guard_en_i),
      .step_i     (step_w),
      .op_o       (op_w)
   );

   stall_guard_acc #(
      .ACC_W      (ACC_W),
      .FILL_STEP  (FILL_STEP),
      .DRAIN_STEP (DRAIN_STEP)
   ) acc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .op_i   (op_w),
      .ceil_i (interval_i),
      .acc_o  (acc_w)
   );

   // Trip latch: set on a full count while running unlocked, cleared by stop
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         trip_q <= 1'b0;
      end else if (!run_i) begin
         trip_q <= 1'b0;
      end else if (guard_en_i && !locked_i && step_w && (acc_w >= interval_i)) begin
         trip_q <= 1'b1;
      end
   end

   assign trip_o = trip_q;

   a_r1_rise_needs_unlocked_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trip_o) |-> $past(run_i && guard_en_i && !locked_i));

   a_r2_locked_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && guard_en_i && locked_i) |=> $stable(acc_w));

   a_r3_trip_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trip_o && run_i) |=> trip_o);

   a_r4_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !trip_o);

   a_r5_drain_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && guard_en_i) |=> (acc_w <= $past(acc_w)));

   a_r7_fill_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && guard_en_i && !locked_i && step_w) |=> (acc_w <= $past(interval_i)));

   a_r8_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !guard_en_i |=> (acc_w == '0));

endmodule

// File: tb/stall_guard_top_tb_top.sv
`timescale 1ns/1ps
module stall_guard_top_tb_top;
   localparam int unsigned ACC_W = 12;
   localparam int unsigned WATCHDOG = 200000;

   typedef struct packed {
      logic             run;
      logic             lock;
      logic             en;
      logic [ACC_W-1:0] lim;
      logic [7:0]       n;
      logic             exp;
      logic [3:0]       req;
   } vec_t;

   // Each row: drive inputs, wait n cycles, then expect trip_o == exp
   localparam vec_t VEC [0:23] = '{
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd5,   1'b0, 4'd5},  // R5 stop at zero
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd40,  1'b0, 4'd1},  // R1 full count, no trip yet
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd1},  // R1 trip next step
      '{1'b1, 1'b1, 1'b1, 12'd40, 8'd3,   1'b1, 4'd3},  // R3 lock keeps trip
      '{1'b1, 1'b0, 1'b0, 12'd40, 8'd2,   1'b1, 4'd3},  // R3 enable low keeps trip
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd1,   1'b0, 4'd4},  // R4 stop clears
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd30,  1'b0, 4'd1},  // R1 partial fill to 30
      '{1'b1, 1'b1, 1'b1, 12'd40, 8'd50,  1'b0, 4'd2},  // R2 hold at 30
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd10,  1'b0, 4'd2},  // R2 reach 40
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd2},  // R2 trip proves hold
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd1,   1'b0, 4'd4},  // R4 stop one step, residue 18
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd22,  1'b0, 4'd6},  // R6 residue refills to 40
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd6},  // R6 early trip
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd2,   1'b0, 4'd5},  // R5 drain 40 -> 18 -> 0
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd40,  1'b0, 4'd5},  // R5 floor at zero
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd5},  // R5 full interval trip
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd1,   1'b0, 4'd4},  // R4 clear, residue 18
      '{1'b1, 1'b0, 1'b0, 12'd40, 8'd60,  1'b0, 4'd8},  // R8 disabled, never trips
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd40,  1'b0, 4'd8},  // R8 residue was wiped
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd8},  // R8 trip at full interval
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd100, 1'b1, 4'd7},  // R7 long unlocked run
      '{1'b0, 1'b0, 1'b1, 12'd40, 8'd1,   1'b0, 4'd4},  // R4 clear, 40 -> 18
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd22,  1'b0, 4'd7},  // R7 ceiling held the count
      '{1'b1, 1'b0, 1'b1, 12'd40, 8'd1,   1'b1, 4'd7}   // R7 trip
   };

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             run_i = 1'b0;
   logic             locked_i = 1'b0;
   logic             guard_en_i = 1'b1;
   logic [ACC_W-1:0] interval_i = 12'd40;
   logic             trip_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   stall_guard_top #(.ACC_W(ACC_W)) dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .locked_i   (locked_i),
      .guard_en_i (guard_en_i),
      .interval_i (interval_i),
      .trip_o     (trip_o)
   );

   function automatic string req_name(input logic [3:0] id);
      case (id)
         4'd1:    return "R1";
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s trip_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic run, input logic lock, input logic en,
                        input logic [ACC_W-1:0] lim);
      run_i = run;
      locked_i = lock;
      guard_en_i = en;
      interval_i = lim;
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      check(trip_o, 1'b0, "R9");  // reset state
      rst_ni = 1'b1;

      for (int i = 0; i < 24; i++) begin
         drive(VEC[i].run, VEC[i].lock, VEC[i].en, VEC[i].lim);
         repeat (int'(VEC[i].n)) @(negedge clk_i);
         check(trip_o, VEC[i].exp, req_name(VEC[i].req));
      end

      // R9: reset in the middle of a trip clears it at once
      drive(1'b0, 1'b0, 1'b1, 12'd40);
      @(negedge clk_i);
      drive(1'b1, 1'b0, 1'b1, 12'd40);
      repeat (41) @(negedge clk_i);
      check(trip_o, 1'b1, "R9");
      #1 rst_ni = 1'b0;
      #0.5;
      check(trip_o, 1'b0, "R9");
      @(negedge clk_i);
      rst_ni = 1'b1;

      // R9: count was cleared by reset, so a short interval needs all its steps
      drive(1'b1, 1'b0, 1'b1, 12'd5);
      repeat (5) @(negedge clk_i);
      check(trip_o, 1'b0, "R9");
      @(negedge clk_i);
      check(trip_o, 1'b1, "R9");

      // R10: zero interval trips on the first unlocked step
      drive(1'b0, 1'b0, 1'b1, 12'd0);
      @(negedge clk_i);
      check(trip_o, 1'b0, "R4");
      drive(1'b1, 1'b1, 1'b1, 12'd0);
      @(negedge clk_i);
      check(trip_o, 1'b0, "R10");
      drive(1'b1, 1'b0, 1'b1, 12'd0);
      @(negedge clk_i);
      check(trip_o, 1'b1, "R10");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk_i);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule